// File: doc/BRIEF.md
# Control-Port Handshake Access Sequencer

This block turns single register requests from a host into complete transactions on a 16-bit parallel control-register port. The port has four strobes: capture-address, capture-data, write and read. It also has one shared 16-bit data-in bus, one acknowledge line and a 16-bit data-out bus. Every strobe is a four-phase handshake. The strobe rises, the block waits for acknowledge to go high, the strobe falls, and the block waits for acknowledge to go low. Each of the two waits has its own timeout.

Every transaction begins with an address phase. A write then places the value on the bus and runs a capture-data handshake followed by a write handshake. A read runs one read handshake and samples data-out while acknowledge is high. A read request may carry a count. The block then repeats the address-plus-read pair for consecutive offsets starting at the base, and returns each word with a valid pulse. A request that breaks the offset or count limits is refused without touching the port. An expired wait aborts the transaction and reports an error.

Top module: `cr_seq`

## Requirements
- R1: After reset, busy_o, done_o, err_o, rvalid_o and all four strobes are 0.
- R2: Every accepted transaction, and every word of a burst, starts with a capture-address handshake. The offset is driven on cr_din_o during that handshake.
- R3: A write (op_wr_i=1) runs capture-address, then capture-data with wdata_i on cr_din_o, then write, in that order. cr_din_o is stable while any strobe is high. The register at the offset receives the value.
- R4: A read (op_wr_i=0) runs capture-address, then read. cr_dout_i is sampled while acknowledge is high. It appears on rdata_o with a one-cycle rvalid_o pulse once acknowledge has fallen.
- R5: A read with count N performs N address-plus-read pairs on offsets base, base+1, … base+N-1 in ascending order, giving exactly N rvalid_o pulses. done_o is raised with the last one.
- R6: A request is refused in either of these cases: the offset is above 0x201F; or it is a read whose count is 0, above 0x42, or whose last offset base+count-1 is above 0x201F. A refused request gets done_o and err_o in the cycle after the request and raises no strobe. Writes ignore the count.
- R7: Each acknowledge wait (for high, and for low) lasts at most TIMEOUT cycles. On expiry, done_o and err_o pulse, all strobes are 0 and no further word is returned.
- R8: At most one strobe is high at any time, and strobes are high only while busy_o is 1.
- R9: busy_o is 1 from the cycle after an accepted request until done_o. Each request gives exactly one done_o pulse. err_o is only high together with done_o. req_i is ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | One-cycle request pulse |
| op_wr_i | input | 1 | 1 = write, 0 = read |
| ofs_i | input | DW | Register offset (burst base for reads) |
| wdata_i | input | DW | Write value |
| cnt_i | input | CNT_W | Number of words for a read |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | Transaction finished (one-cycle pulse) |
| err_o | output | 1 | Refused or timed out; only with done_o |
| rvalid_o | output | 1 | rdata_o carries a new word |
| rdata_o | output | DW | Read word |
| cr_din_o | output | DW | Port data-in bus (offset or value) |
| cr_cap_addr_o | output | 1 | Capture-address strobe |
| cr_cap_data_o | output | 1 | Capture-data strobe |
| cr_write_o | output | 1 | Write strobe |
| cr_read_o | output | 1 | Read strobe |
| cr_ack_i | input | 1 | Port acknowledge |
| cr_dout_i | input | DW | Port data-out bus |

## Verification
The assertions assume that the port side obeys the handshake: acknowledge rises only after a strobe rises, and falls only after the strobe falls. They also assume the host pulses req_i for one cycle while the block is idle. The bench's port model keeps to the handshake for every latency from 0 to 3. The host tasks wait for done_o before issuing the next request. The only deliberate breaks are two faults: an acknowledge that never rises, and one that never falls. These drive the timeout path, and the bench waits for acknowledge to settle low before continuing.

// File: rtl/cr_seq_pkg.sv
`timescale 1ns/1ps
package cr_seq_pkg;
  localparam int NSTB = 4;
  // bit index of each strobe in the strobe vector
  typedef enum logic [1:0] {STB_ADDR, STB_DATA, STB_WRITE, STB_READ} stb_e;
  typedef enum logic [2:0] {PH_IDLE, PH_ADDR, PH_DATA, PH_WRITE, PH_READ} ph_e;
  typedef enum logic [1:0] {HS_IDLE, HS_RISE, HS_FALL} hs_e;
endpackage

// File: rtl/cr_req_check.sv
`timescale 1ns/1ps
module cr_req_check #(
  parameter int DW      = 16,
  parameter int CNT_W   = 7,
  parameter int MAX_CNT = 66,
  parameter int MAX_OFS = 'h201F
) (
  input  logic             is_wr_i,
  input  logic [DW-1:0]    ofs_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             ok_o
);
  logic [DW:0] last;
  logic        ofs_ok, cnt_ok;

  assign last   = {1'b0, ofs_i} + (DW+1)'(cnt_i) - (DW+1)'(1);
  assign ofs_ok = ({1'b0, ofs_i} <= (DW+1)'(MAX_OFS));
  assign cnt_ok = (cnt_i != '0) && (cnt_i <= CNT_W'(MAX_CNT)) &&
                  (last <= (DW+1)'(MAX_OFS));
  assign ok_o   = ofs_ok && (is_wr_i || cnt_ok);
endmodule

// File: rtl/cr_hs_engine.sv
`timescale 1ns/1ps
module cr_hs_engine
  import cr_seq_pkg::*;
#(
  parameter int TIMEOUT = 500000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  stb_e            sel_i,
  input  logic            ack_i,
  output logic [NSTB-1:0] strobe_o,
  output logic            hi_o,
  output logic            done_o,
  output logic            to_o
);
  localparam int TO_W = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;

  hs_e             st_q;
  logic [1:0]      sel_q;
  logic [TO_W-1:0] cnt_q;
  logic            expired;

  assign expired = (cnt_q == TO_W'(TIMEOUT - 1));
  assign hi_o    = (st_q == HS_RISE) && ack_i;

  for (genvar g = 0; g < NSTB; g++) begin : g_stb
    assign strobe_o[g] = (st_q == HS_RISE) && (sel_q == 2'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= HS_IDLE;
      sel_q  <= '0;
      cnt_q  <= '0;
      done_o <= 1'b0;
      to_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      to_o   <= 1'b0;
      unique case (st_q)
        HS_IDLE: if (start_i) begin
          st_q  <= HS_RISE;
          sel_q <= sel_i;
          cnt_q <= '0;
        end
        HS_RISE: begin
          if (ack_i) begin
            st_q  <= HS_FALL;
            cnt_q <= '0;
          end else if (expired) begin
            st_q <= HS_IDLE;
            to_o <= 1'b1;
          end else cnt_q <= cnt_q + 1'b1;
        end
        HS_FALL: begin
          if (!ack_i) begin
            st_q   <= HS_IDLE;
            done_o <= 1'b1;
          end else if (expired) begin
            st_q <= HS_IDLE;
            to_o <= 1'b1;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= HS_IDLE;
      endcase
    end
  end

  p_one_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(strobe_o));
  p_drop_on_ack_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|strobe_o && ack_i) |=> (strobe_o == '0));
  p_ack_low_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !$past(ack_i));
endmodule

// File: rtl/cr_seq.sv
`timescale 1ns/1ps
module cr_seq
  import cr_seq_pkg::*;
#(
  parameter int DW      = 16,
  parameter int CNT_W   = 7,
  parameter int MAX_CNT = 66,
  parameter int MAX_OFS = 'h201F,
  parameter int TIMEOUT = 500000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             op_wr_i,
  input  logic [DW-1:0]    ofs_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic             rvalid_o,
  output logic [DW-1:0]    rdata_o,
  output logic [DW-1:0]    cr_din_o,
  output logic             cr_cap_addr_o,
  output logic             cr_cap_data_o,
  output logic             cr_write_o,
  output logic             cr_read_o,
  input  logic             cr_ack_i,
  input  logic [DW-1:0]    cr_dout_i
);
  ph_e              ph_q;
  logic             is_wr_q, start_q;
  logic [DW-1:0]    ofs_q, wdata_q;
  logic [CNT_W-1:0] left_q;
  logic             req_ok;
  stb_e             sel;
  logic [NSTB-1:0]  stb;
  logic             hs_hi, hs_done, hs_to;

  cr_req_check #(.DW(DW), .CNT_W(CNT_W), .MAX_CNT(MAX_CNT), .MAX_OFS(MAX_OFS)) u_chk (
    .is_wr_i(op_wr_i), .ofs_i(ofs_i), .cnt_i(cnt_i), .ok_o(req_ok));

  always_comb begin
    unique case (ph_q)
      PH_ADDR:  sel = STB_ADDR;
      PH_DATA:  sel = STB_DATA;
      PH_WRITE: sel = STB_WRITE;
      default:  sel = STB_READ;
    endcase
  end

  cr_hs_engine #(.TIMEOUT(TIMEOUT)) u_hs (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_q), .sel_i(sel),
    .ack_i(cr_ack_i), .strobe_o(stb), .hi_o(hs_hi), .done_o(hs_done), .to_o(hs_to));

  assign cr_cap_addr_o = stb[STB_ADDR];
  assign cr_cap_data_o = stb[STB_DATA];
  assign cr_write_o    = stb[STB_WRITE];
  assign cr_read_o     = stb[STB_READ];
  assign busy_o        = (ph_q != PH_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q     <= PH_IDLE;
      is_wr_q  <= 1'b0;
      start_q  <= 1'b0;
      ofs_q    <= '0;
      wdata_q  <= '0;
      left_q   <= '0;
      cr_din_o <= '0;
      done_o   <= 1'b0;
      err_o    <= 1'b0;
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      start_q  <= 1'b0;
      done_o   <= 1'b0;
      err_o    <= 1'b0;
      rvalid_o <= 1'b0;
      if (ph_q == PH_READ && hs_hi) rdata_o <= cr_dout_i;
      if (ph_q == PH_IDLE) begin
        if (req_i) begin
          if (!req_ok) begin
            done_o <= 1'b1;
            err_o  <= 1'b1;
          end else begin
            ph_q     <= PH_ADDR;
            start_q  <= 1'b1;
            is_wr_q  <= op_wr_i;
            ofs_q    <= ofs_i;
            wdata_q  <= wdata_i;
            cr_din_o <= ofs_i;
            left_q   <= op_wr_i ? CNT_W'(1) : cnt_i;
          end
        end
      end else if (hs_to) begin
        ph_q   <= PH_IDLE;
        done_o <= 1'b1;
        err_o  <= 1'b1;
      end else if (hs_done) begin
        unique case (ph_q)
          PH_ADDR: begin
            ph_q    <= is_wr_q ? PH_DATA : PH_READ;
            start_q <= 1'b1;
            if (is_wr_q) cr_din_o <= wdata_q;
          end
          PH_DATA: begin
            ph_q    <= PH_WRITE;
            start_q <= 1'b1;
          end
          PH_WRITE: begin
            ph_q   <= PH_IDLE;
            done_o <= 1'b1;
          end
          default: begin
            rvalid_o <= 1'b1;
            if (left_q == CNT_W'(1)) begin
              ph_q   <= PH_IDLE;
              done_o <= 1'b1;
            end else begin
              left_q   <= left_q - 1'b1;
              ofs_q    <= ofs_q + 1'b1;
              cr_din_o <= ofs_q + 1'b1;
              ph_q     <= PH_ADDR;
              start_q  <= 1'b1;
            end
          end
        endcase
      end
    end
  end

  p_err_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
  p_stb_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb != '0) |-> busy_o);
  p_din_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stb != '0) && $past(stb != '0)) |-> $stable(cr_din_o));
  p_reject_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_i && !req_ok) |=> (done_o && err_o && stb == '0 && !busy_o));
  p_abort_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_to |=> (done_o && err_o && stb == '0 && !rvalid_o));
endmodule

// File: tb/tb_cr_seq.sv
`timescale 1ns/1ps
module tb_cr_seq;
  localparam int TO = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, op_wr = 1'b0;
  logic [15:0] ofs = '0, wdata = '0;
  logic [6:0]  cnt = '0;
  logic        busy, done, err, rvalid;
  logic [15:0] rdata, din;
  logic        s_addr, s_data, s_wr, s_rd;
  logic        ack;
  logic [15:0] dout;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cr_seq #(.TIMEOUT(TO)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .op_wr_i(op_wr), .ofs_i(ofs),
    .wdata_i(wdata), .cnt_i(cnt), .busy_o(busy), .done_o(done), .err_o(err),
    .rvalid_o(rvalid), .rdata_o(rdata), .cr_din_o(din), .cr_cap_addr_o(s_addr),
    .cr_cap_data_o(s_data), .cr_write_o(s_wr), .cr_read_o(s_rd),
    .cr_ack_i(ack), .cr_dout_i(dout));

  // port model
  logic [3:0]  strb;
  logic [15:0] mem [16];
  logic [15:0] m_addr, m_data;
  logic [1:0]  lat = 2'd0;
  logic [3:0]  stall_rise = 4'b0;
  logic        stall_fall = 1'b0;
  int          mcnt;
  assign strb = {s_rd, s_wr, s_data, s_addr};

  function automatic logic [15:0] init_val(int i);
    return 16'h5A00 + 16'(i) * 16'h0103;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ack <= 1'b0; dout <= '0; mcnt <= 0; m_addr <= '0; m_data <= '0;
      for (int i = 0; i < 16; i++) mem[i] <= init_val(i);
    end else if (strb != 0 && !ack) begin
      if ((strb & stall_rise) != 0) mcnt <= 0;
      else if (mcnt >= int'(lat)) begin
        ack <= 1'b1; mcnt <= 0;
        if (strb[0]) m_addr <= din;
        if (strb[1]) m_data <= din;
        if (strb[2]) mem[m_addr[3:0]] <= m_data;
        if (strb[3]) dout <= mem[m_addr[3:0]];
      end else mcnt <= mcnt + 1;
    end else if (strb == 0 && ack) begin
      if (stall_fall) mcnt <= 0;
      else if (mcnt >= int'(lat)) begin ack <= 1'b0; mcnt <= 0; end
      else mcnt <= mcnt + 1;
    end else mcnt <= 0;
  end

  // monitors
  logic [3:0]  strb_d;
  int          log_n, addr_n, multi_n, nobusy_n;
  logic [1:0]  ph_log [8];
  logic [15:0] addr_log [80];
  always @(posedge clk) begin
    strb_d <= strb;
    if (rst_n) begin
      if ($countones(strb) > 1) multi_n <= multi_n + 1;
      if (strb != 0 && !busy) nobusy_n <= nobusy_n + 1;
      for (int b = 0; b < 4; b++)
        if (strb[b] && !strb_d[b]) begin
          if (log_n < 8) ph_log[log_n] <= 2'(b);
          log_n <= log_n + 1;
        end
      if (strb[0] && !strb_d[0]) begin
        if (addr_n < 80) addr_log[addr_n] <= din;
        addr_n <= addr_n + 1;
      end
    end
  end

  logic [15:0] exp_mem [16];
  logic [15:0] rd_buf [80];

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", r, act, exp);
    end
  endtask

  task automatic do_req(input bit wr, input logic [15:0] o, input logic [15:0] wd,
                        input logic [6:0] c, output bit e, output int nw, output int cyc);
    @(negedge clk);
    log_n = 0; addr_n = 0;
    req = 1'b1; op_wr = wr; ofs = o; wdata = wd; cnt = c;
    @(negedge clk);
    req = 1'b0;
    nw = 0; cyc = 1; e = 1'b0;
    forever begin
      if (rvalid) begin
        if (nw < 80) rd_buf[nw] = rdata;
        nw++;
      end
      if (done) begin e = err; break; end
      if (cyc > 20000) begin e = 1'b1; chk("R9 done never came", 0, 1); break; end
      @(negedge clk);
      cyc++;
    end
    @(negedge clk);
    chk("R9 one done pulse", {31'b0, done}, 0);
  endtask

  task automatic wait_ack_low();
    while (ack) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit e; int nw, cyc;
    for (int i = 0; i < 16; i++) exp_mem[i] = init_val(i);
    multi_n = 0; nobusy_n = 0; log_n = 0; addr_n = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", {31'b0, busy}, 0);
    chk("R1 done/err/rvalid", {29'b0, done, err, rvalid}, 0);
    chk("R1 strobes", {28'b0, strb}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 phase order of a write, R4 phase order of a read
    lat = 2'd1;
    do_req(1'b1, 16'h0005, 16'hBEEF, 7'd0, e, nw, cyc);
    exp_mem[5] = 16'hBEEF;
    chk("R3 write err", {31'b0, e}, 0);
    chk("R3 write strobe count", log_n, 3);
    chk("R2 first strobe addr", {30'b0, ph_log[0]}, 0);
    chk("R3 second strobe data", {30'b0, ph_log[1]}, 1);
    chk("R3 third strobe write", {30'b0, ph_log[2]}, 2);
    chk("R2 offset on bus", {16'b0, addr_log[0]}, 32'h5);
    do_req(1'b0, 16'h0005, 16'h0, 7'd1, e, nw, cyc);
    chk("R4 read strobe count", log_n, 2);
    chk("R4 second strobe read", {30'b0, ph_log[1]}, 3);
    chk("R4 one word", nw, 1);
    chk("R4 data", {16'b0, rd_buf[0]}, {16'b0, exp_mem[5]});

    // R3/R4 sweep over latencies and offsets up to the top limit
    for (int l = 0; l < 4; l++) begin
      lat = 2'(l);
      for (int i = 0; i < 16; i++) begin
        logic [15:0] o, v;
        o = 16'h2010 + 16'(i);
        v = 16'hC000 ^ (16'(l) << 8) ^ (16'(i) * 16'h0011);
        do_req(1'b1, o, v, 7'd5, e, nw, cyc);
        exp_mem[i] = v;
        chk("R3 sweep write ok", {31'b0, e}, 0);
        do_req(1'b0, o, 16'h0, 7'd1, e, nw, cyc);
        chk("R4 sweep read", {16'b0, rd_buf[0]}, {16'b0, exp_mem[i]});
      end
    end

    // R5 burst of maximum length
    lat = 2'd0;
    do_req(1'b0, 16'h0000, 16'h0, 7'h42, e, nw, cyc);
    chk("R5 burst err", {31'b0, e}, 0);
    chk("R5 burst words", nw, 66);
    chk("R5 burst addr phases", addr_n, 66);
    for (int k = 0; k < 66; k++) begin
      chk("R5 burst data", {16'b0, rd_buf[k]}, {16'b0, exp_mem[k % 16]});
      chk("R5 burst offset order", {16'b0, addr_log[k]}, k);
    end
    do_req(1'b0, 16'h1FDE, 16'h0, 7'h42, e, nw, cyc);
    chk("R5 burst ending at limit", {31'b0, e}, 0);
    chk("R5 burst ending at limit words", nw, 66);

    // R6 refused requests
    do_req(1'b1, 16'h2020, 16'h1234, 7'd1, e, nw, cyc);
    chk("R6 write offset too high", {31'b0, e}, 1);
    chk("R6 no strobe", log_n, 0);
    chk("R6 next cycle", cyc, 1);
    do_req(1'b0, 16'h0000, 16'h0, 7'h43, e, nw, cyc);
    chk("R6 count too high", {31'b0, e}, 1);
    chk("R6 no strobe cnt", log_n, 0);
    do_req(1'b0, 16'h0000, 16'h0, 7'd0, e, nw, cyc);
    chk("R6 count zero", {31'b0, e}, 1);
    do_req(1'b0, 16'h1FDF, 16'h0, 7'h42, e, nw, cyc);
    chk("R6 last offset past limit", {31'b0, e}, 1);
    chk("R6 no word", nw, 0);
    chk("R6 no strobe last", log_n, 0);

    // R7 timeouts
    stall_rise = 4'b0001;
    do_req(1'b1, 16'h0003, 16'h7777, 7'd1, e, nw, cyc);
    chk("R7 addr stall err", {31'b0, e}, 1);
    chk("R7 abort time low", {31'b0, cyc >= TO}, 1);
    chk("R7 abort time high", {31'b0, cyc <= TO + 3}, 1);
    chk("R7 strobes cleared", {28'b0, strb}, 0);
    stall_rise = 4'b0100;
    do_req(1'b1, 16'h0003, 16'h7777, 7'd1, e, nw, cyc);
    chk("R7 write stall err", {31'b0, e}, 1);
    stall_rise = 4'b0000;
    do_req(1'b0, 16'h0003, 16'h0, 7'd1, e, nw, cyc);
    chk("R7 register untouched", {16'b0, rd_buf[0]}, {16'b0, exp_mem[3]});
    stall_fall = 1'b1;
    do_req(1'b0, 16'h0002, 16'h0, 7'd4, e, nw, cyc);
    chk("R7 fall stall err", {31'b0, e}, 1);
    chk("R7 fall stall no word", nw, 0);
    chk("R7 fall stall strobes", {28'b0, strb}, 0);
    stall_fall = 1'b0;
    wait_ack_low();

    // R9 request while busy is ignored
    lat = 2'd2;
    @(negedge clk);
    log_n = 0;
    req = 1'b1; op_wr = 1'b0; ofs = 16'h0001; cnt = 7'd1;
    @(negedge clk);
    chk("R9 busy after accept", {31'b0, busy}, 1);
    op_wr = 1'b1; ofs = 16'h0009; wdata = 16'hDEAD;
    @(negedge clk);
    req = 1'b0;
    while (!done) @(negedge clk);
    chk("R9 ignored req no error", {31'b0, err}, 0);
    chk("R9 read returned", {16'b0, rdata}, {16'b0, exp_mem[1]});
    @(negedge clk);
    chk("R9 idle after", {31'b0, busy}, 0);
    chk("R9 ignored req no strobes", log_n, 2);
    do_req(1'b0, 16'h0009, 16'h0, 7'd1, e, nw, cyc);
    chk("R9 ignored write absent", {16'b0, rd_buf[0]}, {16'b0, exp_mem[9]});

    chk("R8 one strobe at a time", multi_n, 0);
    chk("R8 strobes only when busy", nobusy_n, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule